// File: doc/BRIEF.md
# Field-Gap Pulse-Interval Decoder

A reader sends commands to a passive tag by switching its carrier off for short moments. This block turns that gap pattern into bits. It watches a gap-detect level that is already synchronous to the clock. It counts only on cycles where the field-clock enable is high. It measures how long each field-present stretch lasts between two gaps, and it maps that length to a '0', a '1' or an error.

The first accepted gap opens a frame and moves the block into downlink mode. Each later gap ends one interval and emits one bit, together with a valid strobe and a running bit count. A quiet field longer than the timeout closes the frame with a done pulse. The done pulse carries the final count. An out-of-window interval or gap aborts the frame with an error pulse.

Two timing sets exist, a normal one and a fast one. The set is chosen per frame by the level of the fast-select input when the start gap ends.

Top module: `field_gap_decoder`

## Requirements
- R1: After reset, busy, bit_valid, bit_data, bit_count, frame_done and frame_err are all 0.
- R2: A gap lasting 10 to 50 enabled ticks while idle is accepted as the start gap, and busy rises on the first field-present tick after it. A shorter or longer first gap leaves the block idle, with no output activity.
- R3: In the normal set, a field-present interval of 16 to 31 ticks followed by a gap emits bit 0, and 48 to 63 ticks emits bit 1. The bit appears as a one-cycle bit_valid pulse on the first gap tick, bit_count rises by one, and bits come out in arrival order.
- R4: In the fast set (fast_i = 1 when the start gap ends), an interval of 8 to 15 ticks emits bit 0 and 24 to 31 ticks emits bit 1.
- R5: An interval that falls outside both windows of the active set gives a one-cycle frame_err pulse and emits no bit. In the same cycle busy is 0 and bit_count is 0.
- R6: A gap inside a frame must last 8 to 50 ticks. A gap of 7 ticks or fewer raises frame_err on the first field-present tick after it. A gap still present at tick 51 raises frame_err on that tick.
- R7: If no gap arrives for more than 64 ticks (normal) or more than 32 ticks (fast) after at least one bit, frame_done pulses for one cycle on tick 65 (normal) or tick 33 (fast). bit_count still shows the final count in that cycle, and returns to 0 in the next cycle with busy at 0. frame_done and frame_err never pulse together.
- R8: A start gap followed only by the timeout produces no frame_done, no frame_err and no bit, and busy falls.
- R9: bit_count saturates at 127 and does not wrap.
- R10: Cycles with fc_en low are ignored: gap_i is not sampled and no count advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fc_en | input | 1 | Field-clock enable, one tick per field clock |
| gap_i | input | 1 | Synchronous gap level, 1 = field absent |
| fast_i | input | 1 | Selects the fast timing set, sampled when the start gap ends |
| busy | output | 1 | Downlink mode active |
| bit_valid | output | 1 | One-cycle strobe for a decoded bit |
| bit_data | output | 1 | Value of the decoded bit |
| bit_count | output | 7 | Bits decoded in the current frame, saturating |
| frame_done | output | 1 | One-cycle pulse at the frame timeout |
| frame_err | output | 1 | One-cycle pulse on an interval or gap error |

## Verification
The bench builds the block with its default parameters: 7-bit counters and the stated normal and fast windows. With these values both edges of every window can be reached: each valid interval bound, each error length just outside it, and the exact tick of both timeouts. A fast-set frame of 130 bits fits in a few thousand clocks, so the 127 saturation point is exercised directly. One frame is sent with the field-clock enable at half rate and with misleading gap values on the disabled cycles, to show that only enabled ticks count.

// File: rtl/fgd_pkg.sv
package fgd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_HIGH  = 2'd2,
    ST_GAP   = 2'd3
  } fgd_state_e;
endpackage

// File: rtl/fgd_sat_counter.sv
module fgd_sat_counter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load_one,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)                     cnt_d = '0;
    else if (load_one)           cnt_d = ONE;
    else if (inc && cnt != MAXV) cnt_d = cnt + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R9
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !load_one && cnt == MAXV) |=> (cnt == MAXV));
endmodule

// File: rtl/fgd_window_check.sv
module fgd_window_check #(
  parameter int W        = 7,
  parameter int N0_MIN   = 16,
  parameter int N0_MAX   = 31,
  parameter int N1_MIN   = 48,
  parameter int N1_MAX   = 63,
  parameter int N_TO     = 64,
  parameter int F0_MIN   = 8,
  parameter int F0_MAX   = 15,
  parameter int F1_MIN   = 24,
  parameter int F1_MAX   = 31,
  parameter int F_TO     = 32,
  parameter int SGAP_MIN = 10,
  parameter int WGAP_MIN = 8,
  parameter int GAP_MAX  = 50
) (
  input  logic [W-1:0] cnt,
  input  logic         fast,
  output logic         is_zero,
  output logic         is_one,
  output logic         at_timeout,
  output logic         start_ok,
  output logic         wgap_ok,
  output logic         gap_over
);
  int c;
  int z_lo, z_hi, o_lo, o_hi, to_lim;

  always_comb begin
    c = int'(cnt);
    if (fast) begin
      z_lo = F0_MIN; z_hi = F0_MAX; o_lo = F1_MIN; o_hi = F1_MAX; to_lim = F_TO;
    end else begin
      z_lo = N0_MIN; z_hi = N0_MAX; o_lo = N1_MIN; o_hi = N1_MAX; to_lim = N_TO;
    end
    is_zero    = (c >= z_lo) && (c <= z_hi);
    is_one     = (c >= o_lo) && (c <= o_hi);
    at_timeout = (c == to_lim);
    start_ok   = (c >= SGAP_MIN) && (c <= GAP_MAX);
    wgap_ok    = (c >= WGAP_MIN);
    gap_over   = (c >= GAP_MAX);
  end
endmodule

// File: rtl/field_gap_decoder.sv
module field_gap_decoder
  import fgd_pkg::*;
#(
  parameter int CNT_W    = 7,
  parameter int BCNT_W   = 7,
  parameter int N0_MIN   = 16,
  parameter int N0_MAX   = 31,
  parameter int N1_MIN   = 48,
  parameter int N1_MAX   = 63,
  parameter int N_TO     = 64,
  parameter int F0_MIN   = 8,
  parameter int F0_MAX   = 15,
  parameter int F1_MIN   = 24,
  parameter int F1_MAX   = 31,
  parameter int F_TO     = 32,
  parameter int SGAP_MIN = 10,
  parameter int WGAP_MIN = 8,
  parameter int GAP_MAX  = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fc_en,
  input  logic              gap_i,
  input  logic              fast_i,
  output logic              busy,
  output logic              bit_valid,
  output logic              bit_data,
  output logic [BCNT_W-1:0] bit_count,
  output logic              frame_done,
  output logic              frame_err
);
  localparam logic [BCNT_W-1:0] BMAX = '1;

  fgd_state_e   state_q, state_d;
  logic         fast_q, fast_d;
  logic         valid_d, data_d, done_d, err_d;
  logic         t_clr, t_load, t_inc;
  logic         b_clr, b_inc;
  logic [CNT_W-1:0] tick_cnt;
  logic         w_zero, w_one, w_to, w_start, w_wgap, w_over;

  fgd_sat_counter #(.W(CNT_W)) u_ticks (
    .clk(clk), .rst_n(rst_n), .clr(t_clr), .load_one(t_load), .inc(t_inc), .cnt(tick_cnt)
  );

  fgd_sat_counter #(.W(BCNT_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .clr(b_clr), .load_one(1'b0), .inc(b_inc), .cnt(bit_count)
  );

  fgd_window_check #(
    .W(CNT_W), .N0_MIN(N0_MIN), .N0_MAX(N0_MAX), .N1_MIN(N1_MIN), .N1_MAX(N1_MAX),
    .N_TO(N_TO), .F0_MIN(F0_MIN), .F0_MAX(F0_MAX), .F1_MIN(F1_MIN), .F1_MAX(F1_MAX),
    .F_TO(F_TO), .SGAP_MIN(SGAP_MIN), .WGAP_MIN(WGAP_MIN), .GAP_MAX(GAP_MAX)
  ) u_win (
    .cnt(tick_cnt), .fast(fast_q), .is_zero(w_zero), .is_one(w_one), .at_timeout(w_to),
    .start_ok(w_start), .wgap_ok(w_wgap), .gap_over(w_over)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    fast_d  = fast_q;
    valid_d = 1'b0;
    data_d  = bit_data;
    done_d  = 1'b0;
    err_d   = 1'b0;
    t_clr   = 1'b0;
    t_load  = 1'b0;
    t_inc   = 1'b0;
    b_clr   = frame_done;
    b_inc   = 1'b0;
    if (fc_en) begin
      unique case (state_q)
        ST_IDLE: begin
          if (gap_i) begin
            state_d = ST_START;
            t_load  = 1'b1;
          end
        end
        ST_START: begin
          if (gap_i) begin
            t_inc = 1'b1;
          end else if (w_start) begin
            state_d = ST_HIGH;
            t_load  = 1'b1;
            fast_d  = fast_i;
            b_clr   = 1'b1;
          end else begin
            state_d = ST_IDLE;
            t_clr   = 1'b1;
          end
        end
        ST_HIGH: begin
          if (gap_i) begin
            if (w_zero || w_one) begin
              valid_d = 1'b1;
              data_d  = w_one;
              b_inc   = 1'b1;
              state_d = ST_GAP;
              t_load  = 1'b1;
            end else begin
              err_d   = 1'b1;
              state_d = ST_IDLE;
              t_clr   = 1'b1;
              b_clr   = 1'b1;
            end
          end else if (w_to) begin
            done_d  = (bit_count != '0);
            state_d = ST_IDLE;
            t_clr   = 1'b1;
          end else begin
            t_inc = 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_i) begin
            if (w_over) begin
              err_d   = 1'b1;
              state_d = ST_IDLE;
              t_clr   = 1'b1;
              b_clr   = 1'b1;
            end else begin
              t_inc = 1'b1;
            end
          end else if (w_wgap) begin
            state_d = ST_HIGH;
            t_load  = 1'b1;
          end else begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
            t_clr   = 1'b1;
            b_clr   = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      fast_q     <= 1'b0;
      bit_valid  <= 1'b0;
      bit_data   <= 1'b0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      state_q    <= state_d;
      fast_q     <= fast_d;
      bit_valid  <= valid_d;
      bit_data   <= data_d;
      frame_done <= done_d;
      frame_err  <= err_d;
    end
  end

  assign busy = (state_q == ST_HIGH) || (state_q == ST_GAP);

  // R7
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_err));

  // R8
  done_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (bit_count != '0));

  // R3
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && $past(bit_count) != BMAX) |-> (bit_count == $past(bit_count) + 1'b1));

  // R5
  err_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (!busy && bit_count == '0));

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (bit_count == '0 && !busy));

  // R10
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en |=> $stable(state_q));
endmodule

// File: tb/field_gap_decoder_tb.sv
module field_gap_decoder_tb;
  logic clk = 1'b0;
  logic rst_n, fc_en, gap_i, fast_i;
  logic busy, bit_valid, bit_data, frame_done, frame_err;
  logic [6:0] bit_count;

  always #10 clk = ~clk;

  field_gap_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .gap_i(gap_i), .fast_i(fast_i),
    .busy(busy), .bit_valid(bit_valid), .bit_data(bit_data), .bit_count(bit_count),
    .frame_done(frame_done), .frame_err(frame_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit slow = 1'b0;

  int nbits, done_seen, err_seen, done_cnt;
  logic rx [0:255];

  always @(posedge clk) begin
    #2;
    if (bit_valid) begin
      if (nbits < 256) rx[nbits] = bit_data;
      nbits++;
    end
    if (frame_done) begin
      done_seen++;
      done_cnt = int'(bit_count);
    end
    if (frame_err) err_seen++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    nbits = 0; done_seen = 0; err_seen = 0; done_cnt = -1;
  endtask

  task automatic tk(input logic g);
    if (slow) begin
      fc_en = 1'b0; gap_i = ~g;
      @(negedge clk);
    end
    fc_en = 1'b1; gap_i = g;
    @(negedge clk);
  endtask

  task automatic run(input logic g, input int n);
    for (int i = 0; i < n; i++) tk(g);
  endtask

  task automatic settle();
    run(1'b0, 80);
    clear_log();
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 bit_valid", bit_valid, 0);
    check("R1 bit_data", bit_data, 0);
    check("R1 bit_count", bit_count, 0);
    check("R1 frame_done", frame_done, 0);
    check("R1 frame_err", frame_err, 0);
  endtask

  task automatic t_normal();
    int iv [6] = '{24, 54, 16, 31, 48, 63};
    int gp [6] = '{8, 50, 20, 12, 30, 9};
    int ex [6] = '{0, 1, 0, 0, 1, 1};
    fast_i = 1'b0;
    settle();
    run(1'b1, 20);
    tk(1'b0);
    check("R2 busy after start gap", busy, 1);
    run(1'b0, 23);
    for (int k = 0; k < 6; k++) begin
      if (k > 0) run(1'b0, iv[k]);
      run(1'b1, gp[k]);
    end
    check("R3 normal bit count", nbits, 6);
    for (int k = 0; k < 6; k++) check("R3 normal bit value", int'(rx[k]), ex[k]);
    check("R6 valid gaps no error", err_seen, 0);
    run(1'b0, 64);
    check("R7 no done at tick 64", done_seen, 0);
    tk(1'b0);
    check("R7 done at tick 65", done_seen, 1);
    check("R7 final count", done_cnt, 6);
    tk(1'b0);
    check("R7 count cleared", bit_count, 0);
    check("R7 busy cleared", busy, 0);
  endtask

  task automatic t_fast();
    int iv [6] = '{12, 28, 8, 15, 24, 31};
    int ex [6] = '{0, 1, 0, 0, 1, 1};
    fast_i = 1'b1;
    settle();
    run(1'b1, 10);
    for (int k = 0; k < 6; k++) begin
      run(1'b0, iv[k]);
      run(1'b1, 8);
    end
    fast_i = 1'b0;
    check("R4 fast bit count", nbits, 6);
    for (int k = 0; k < 6; k++) check("R4 fast bit value", int'(rx[k]), ex[k]);
    run(1'b0, 32);
    check("R7 fast no done at 32", done_seen, 0);
    tk(1'b0);
    check("R7 fast done at 33", done_seen, 1);
    check("R7 fast final count", done_cnt, 6);
  endtask

  task automatic t_start_gap();
    settle();
    run(1'b1, 9); run(1'b0, 24);
    check("R2 short start busy", busy, 0);
    run(1'b1, 8); run(1'b0, 70);
    check("R2 short start no bits", nbits, 0);
    settle();
    run(1'b1, 51); run(1'b0, 24);
    check("R2 long start busy", busy, 0);
    run(1'b1, 8); run(1'b0, 70);
    check("R2 long start no bits", nbits + err_seen + done_seen, 0);
    settle();
    run(1'b1, 50); tk(1'b0);
    check("R2 start gap 50 accepted", busy, 1);
    run(1'b0, 70);
    check("R8 lone start no done", done_seen, 0);
    check("R8 lone start no err", err_seen, 0);
    check("R8 lone start busy", busy, 0);
  endtask

  task automatic bad_interval(input logic f, input int iv, input string req);
    fast_i = f;
    settle();
    run(1'b1, 12);
    run(1'b0, f ? 12 : 24);
    run(1'b1, 8);
    run(1'b0, iv - 1);
    tk(1'b0);
    tk(1'b1);
    check({req, " err pulse"}, err_seen, 1);
    check({req, " one bit only"}, nbits, 1);
    check({req, " busy"}, busy, 0);
    check({req, " count"}, bit_count, 0);
    run(1'b1, 3);
    fast_i = 1'b0;
  endtask

  task automatic t_intervals();
    bad_interval(1'b0, 15, "R5 normal 15");
    bad_interval(1'b0, 32, "R5 normal 32");
    bad_interval(1'b0, 47, "R5 normal 47");
    bad_interval(1'b0, 64, "R5 normal 64");
    bad_interval(1'b1, 7,  "R5 fast 7");
    bad_interval(1'b1, 16, "R5 fast 16");
    bad_interval(1'b1, 32, "R5 fast 32");
  endtask

  task automatic t_wgap();
    fast_i = 1'b0;
    settle();
    run(1'b1, 12); run(1'b0, 24); run(1'b1, 7); tk(1'b0);
    check("R6 short gap err", err_seen, 1);
    check("R6 short gap busy", busy, 0);
    settle();
    run(1'b1, 12); run(1'b0, 24); run(1'b1, 50);
    check("R6 gap 50 no err", err_seen, 0);
    tk(1'b1);
    check("R6 gap 51 err", err_seen, 1);
    check("R6 gap 51 count", bit_count, 0);
    run(1'b1, 3);
  endtask

  task automatic t_enable();
    fast_i = 1'b0;
    settle();
    slow = 1'b1;
    run(1'b1, 15);
    run(1'b0, 54); run(1'b1, 10);
    run(1'b0, 24); run(1'b1, 10);
    run(1'b0, 65);
    slow = 1'b0;
    check("R10 gated bit count", nbits, 2);
    check("R10 gated bit 0", int'(rx[0]), 1);
    check("R10 gated bit 1", int'(rx[1]), 0);
    check("R10 gated done", done_seen, 1);
    check("R10 gated no err", err_seen, 0);
  endtask

  task automatic t_saturate();
    fast_i = 1'b1;
    settle();
    run(1'b1, 10);
    for (int k = 0; k < 130; k++) begin
      run(1'b0, (k % 2 == 0) ? 12 : 28);
      run(1'b1, 8);
    end
    check("R9 saturated count", bit_count, 127);
    check("R9 bits strobed", nbits, 130);
    run(1'b0, 33);
    check("R9 done count 127", done_cnt, 127);
    fast_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; fc_en = 1'b0; gap_i = 1'b0; fast_i = 1'b0;
    clear_log();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_fast();
    t_start_gap();
    t_intervals();
    t_wgap();
    t_enable();
    t_saturate();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule